// File: doc/BRIEF.md
# Sampled-Address Slave Select Router

This block takes one active-low slave-select line from a bus master and steers it to one of four slave-select outputs. A 2-bit route address picks the output. The address is not decoded directly. It first passes through a two-flop synchroniser. A free-running sample tick then reads it once every `SAMPLE_DIV` system clocks, and the route changes only after `AGREE` consecutive ticks have read the same address.

Each output has a data bit and an output-enable bit. The pad logic outside the block releases an output whose enable is low, and an external pull-up then holds that line at its idle high level. While an output is unselected, its data bit is also held high.

When the route moves to another output, the block first drops every enable for at least one clock. Only then does it enable the new output. This way two slaves are never selected together. A short address pulse that the sampler sees only once is ignored.

Top module: `ssel_router`

## Requirements
- R1: Route address value k (with bit 0 of `route_addr` as the low-order bit) selects output k: 00 selects output 0, 01 selects output 1, 10 selects output 2 and 11 selects output 3. Selection means `ss_n_oe` equals the one-hot value with only bit k set.
- R2: A selected output's `ss_n_out` bit copies `slave_sel_n` one clock later. Every unselected output has its `ss_n_oe` bit at 0 and its `ss_n_out` bit at 1.
- R3: The synchronised address is read only on sample ticks, one every `SAMPLE_DIV` clocks. For at least `SAMPLE_DIV`+1 clocks after an address change, `ss_n_oe` keeps its old value.
- R4: A new route takes effect only after `AGREE` (default 2) consecutive sample ticks read the same address. An address held for fewer than `SAMPLE_DIV` clocks leaves the route unchanged.
- R5: At most one `ss_n_oe` bit is ever 1. Between two different non-zero enable patterns there is at least one clock where all enables are 0. A switch never enables an output other than the old one or the new one.
- R6: After reset, all `ss_n_oe` bits are 0 and all `ss_n_out` bits are 1 until the first address has been confirmed.
- R7: An address held stable reaches `ss_n_oe` within 2*`SAMPLE_DIV`+6 clocks of the change at `route_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_sel_n | input | 1 | Active-low slave select from the master |
| route_addr | input | ADDR_W | Asynchronous route address |
| ss_n_out | output | 2**ADDR_W | Data bit per slave-select output |
| ss_n_oe | output | 2**ADDR_W | Output-enable per slave-select output |

## Verification
The bench pulses the address for one clock less than a sample period and checks that the route stays where it was. A design that acts on a single sample would briefly select the wrong slave, or settle on it.

It also changes the address twice within two sample periods. On every clock it checks that only the old output or the final output was ever enabled. A decoder without qualification would flash the unrelated middle output.

Each switch is watched for the all-off gap and for two enables at once. A design that does make-before-break would drive two slaves during the handover. Separate checks look at the earliest clock where a change is allowed and at the idle state before the first confirmation. These catch a design that samples every clock or that comes out of reset with output 0 already enabled.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int unsigned DEF_ADDR_W     = 2;
  localparam int unsigned DEF_SAMPLE_DIV = 8;
  localparam int unsigned DEF_AGREE      = 2;
  localparam int unsigned DEF_SYNC_STG   = 2;
endpackage

// File: rtl/ssr_tick.sv
module ssr_tick #(
  parameter int unsigned SAMPLE_DIV = 8
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CNT_W = (SAMPLE_DIV > 2) ? $clog2(SAMPLE_DIV) : 1;
  logic [CNT_W-1:0] cnt;

  assign tick = (cnt == CNT_W'(SAMPLE_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R3: ticks are isolated single-cycle pulses
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/ssr_sync.sv
module ssr_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ssr_qualify.sv
module ssr_qualify #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned AGREE  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr_s,
  output logic [ADDR_W-1:0] conf_addr,
  output logic              conf_valid
);
  localparam int unsigned RUN_W = $clog2(AGREE + 1);

  logic [ADDR_W-1:0] last;
  logic [RUN_W-1:0]  run, run_n;

  always_comb begin
    if (run != '0 && addr_s == last)
      run_n = (run == RUN_W'(AGREE)) ? run : run + 1'b1;
    else
      run_n = RUN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last       <= '0;
      run        <= '0;
      conf_addr  <= '0;
      conf_valid <= 1'b0;
    end else if (tick) begin
      last <= addr_s;
      run  <= run_n;
      if (run_n == RUN_W'(AGREE)) begin
        conf_addr  <= addr_s;
        conf_valid <= 1'b1;
      end
    end
  end

  // R3: confirmed route only moves on a sample tick
  assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(conf_addr) && $stable(conf_valid)));

  // R4: a newly confirmed address equals the sample read at that tick
  assert_confirm_source_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && run_n == RUN_W'(AGREE)) |=> (conf_addr == $past(addr_s)));
endmodule

// File: rtl/ssr_route.sv
module ssr_route #(
  parameter int unsigned ADDR_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      conf_addr,
  input  logic                   conf_valid,
  input  logic                   slave_sel_n,
  output logic [(1<<ADDR_W)-1:0] ss_n_out,
  output logic [(1<<ADDR_W)-1:0] ss_n_oe
);
  localparam int unsigned NUM_OUT = 1 << ADDR_W;

  logic [NUM_OUT-1:0] target, oe_d;

  genvar i;
  generate
    for (i = 0; i < NUM_OUT; i++) begin : g_dec
      assign target[i] = conf_valid && (conf_addr == ADDR_W'(i));
    end
  endgenerate

  always_comb begin
    oe_d = ss_n_oe;
    if (conf_valid && ss_n_oe != target)
      oe_d = (ss_n_oe != '0) ? '0 : target;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_n_oe  <= '0;
      ss_n_out <= '1;
    end else begin
      ss_n_oe  <= oe_d;
      ss_n_out <= {NUM_OUT{slave_sel_n}} | ~oe_d;
    end
  end

  // R5: never more than one enable
  assert_single_enable_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ss_n_oe));

  // R5: two consecutive non-zero enables must be identical (break before make)
  assert_break_before_make_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(ss_n_oe) != '0 && ss_n_oe != '0) |-> (ss_n_oe == $past(ss_n_oe)));

  // R2: released outputs hold their data bit high
  assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
    ((~ss_n_oe & ~ss_n_out) == '0));

  // R6: nothing enabled before the first confirmation
  assert_idle_until_confirmed_R6: assert property (@(posedge clk) disable iff (rst)
    !conf_valid |-> (ss_n_oe == '0));
endmodule

// File: rtl/ssel_router.sv
module ssel_router
  import ssr_pkg::*;
#(
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned SAMPLE_DIV = DEF_SAMPLE_DIV,
  parameter int unsigned AGREE      = DEF_AGREE,
  parameter int unsigned SYNC_STG   = DEF_SYNC_STG
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   slave_sel_n,
  input  logic [ADDR_W-1:0]      route_addr,
  output logic [(1<<ADDR_W)-1:0] ss_n_out,
  output logic [(1<<ADDR_W)-1:0] ss_n_oe
);
  logic              tick;
  logic [ADDR_W-1:0] addr_s;
  logic [ADDR_W-1:0] conf_addr;
  logic              conf_valid;

  ssr_tick #(.SAMPLE_DIV(SAMPLE_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  ssr_sync #(.WIDTH(ADDR_W), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d(route_addr), .q(addr_s)
  );

  ssr_qualify #(.ADDR_W(ADDR_W), .AGREE(AGREE)) u_qual (
    .clk(clk), .rst(rst), .tick(tick), .addr_s(addr_s),
    .conf_addr(conf_addr), .conf_valid(conf_valid)
  );

  ssr_route #(.ADDR_W(ADDR_W)) u_route (
    .clk(clk), .rst(rst), .conf_addr(conf_addr), .conf_valid(conf_valid),
    .slave_sel_n(slave_sel_n), .ss_n_out(ss_n_out), .ss_n_oe(ss_n_oe)
  );
endmodule

// File: tb/ssel_router_test.sv
`timescale 1ns/1ps
module ssel_router_test;
  localparam int DIV    = 8;
  localparam int SETTLE = 2*DIV + 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_n = 1'b1;
  logic [1:0] addr = 2'd0;
  wire  [3:0] ss_out, ss_oe;

  ssel_router #(.ADDR_W(2), .SAMPLE_DIV(DIV), .AGREE(2), .SYNC_STG(2)) uut (
    .clk(clk), .rst(rst), .slave_sel_n(sel_n), .route_addr(addr),
    .ss_n_out(ss_out), .ss_n_oe(ss_oe)
  );

  always #5 clk = ~clk;

  typedef struct { logic [3:0] oe; string req; } exp_t;
  exp_t sb[$];

  int checks = 0, fails = 0, gap_cycles = 0;
  logic [3:0] allowed = 4'b0000;
  logic [3:0] prev_oe = 4'b0000;
  bit seen_en = 0, done = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: set address, hold, then queue the expected route
  task automatic drive(logic [1:0] a, int hold, logic [3:0] exp_oe, string req, bit widen);
    if (widen) allowed = allowed | exp_oe;
    addr = a;
    wait_n(hold);
    sb.push_back('{oe: exp_oe, req: req});
  endtask

  // monitor: scoreboard compare plus per-cycle handover guards (R5)
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(ss_oe == e.oe, e.req, "route enable", ss_oe, e.oe);
        allowed = e.oe;
      end
      if (!$onehot0(ss_oe) || ((ss_oe & ~allowed) != 4'b0000))
        check(0, "R5", "enable outside allowed set", ss_oe, allowed);
      if (prev_oe != 4'b0000 && ss_oe != 4'b0000 && prev_oe != ss_oe)
        check(0, "R5", "switch without gap", ss_oe, 0);
      if (ss_oe != 4'b0000) seen_en = 1;
      else if (seen_en) gap_cycles++;
      prev_oe = ss_oe;
    end
  end

  initial begin
    int g0;
    wait_n(3);
    rst = 1'b0;
    @(negedge clk);
    check(ss_oe == 4'b0000, "R6", "enables after reset", ss_oe, 0);
    check(ss_out == 4'b1111, "R6", "data after reset", ss_out, 4'hf);
    wait_n(DIV + 2);
    check(ss_oe == 4'b0000, "R6", "enables before confirmation", ss_oe, 0);

    drive(2'd0, SETTLE, 4'b0001, "R1/R7 addr 00", 1);
    @(negedge clk);
    sel_n = 1'b0; wait_n(2);
    check(ss_out == 4'b1110, "R2", "output 0 follows low select", ss_out, 4'he);
    sel_n = 1'b1; wait_n(2);
    check(ss_out == 4'b1111, "R2", "output 0 follows high select", ss_out, 4'hf);

    drive(2'd1, SETTLE, 4'b0010, "R1/R7 addr 01", 1);
    @(negedge clk);

    g0 = gap_cycles;
    allowed = 4'b0110;
    addr = 2'd2;
    wait_n(DIV + 1);
    check(ss_oe == 4'b0010, "R3", "no change before two periods", ss_oe, 4'b0010);
    drive(2'd2, SETTLE - DIV - 1, 4'b0100, "R1/R7 addr 10", 1);
    @(negedge clk);
    check(gap_cycles > g0, "R5", "all-off gap during switch", gap_cycles - g0, 1);

    drive(2'd3, SETTLE, 4'b1000, "R1/R7 addr 11", 1);
    @(negedge clk);
    sel_n = 1'b0; wait_n(2);
    check(ss_out == 4'b0111, "R2", "output 3 low, others high", ss_out, 4'h7);

    // short pulse to 01 must be ignored (R4)
    addr = 2'd1;
    wait_n(DIV - 1);
    drive(2'd3, SETTLE, 4'b1000, "R4 short pulse ignored", 0);
    @(negedge clk);
    check(ss_out == 4'b0111, "R4", "data unchanged after pulse", ss_out, 4'h7);

    // two changes within two periods: never output 2 (R4, R5)
    allowed = 4'b1001;
    addr = 2'd2;
    wait_n(DIV - 1);
    drive(2'd0, SETTLE, 4'b0001, "R4/R5 double change", 0);
    @(negedge clk);
    check(ss_out == 4'b1110, "R2", "output 0 after double change", ss_out, 4'he);

    wait_n(2);
    done = 1;
    check(sb.size() == 0, "R7", "scoreboard drained", sb.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R7 watchdog expired: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule